// File: doc/BRIEF.md
# Warm Reset Handshake Timeout Recorder

This block runs the handshakes that come before a hardware-sequenced warm or watchdog reset. Five agents are served one at a time: SDRAM self-refresh entry, the FPGA fabric, the trace router master stall, the L2 flush, and the interconnect debug handshake. For each agent the sequencer raises a request and waits a bounded number of cycles for the acknowledge. If the acknowledge does not arrive in time, the sequencer records the timeout and moves on. When the last handshake ends, the sequencer emits a one-cycle done pulse, and the reset controller can then apply the warm reset.

Each timeout sets a sticky flag in a 32-bit status word. Software reads the word through a small register port and clears flags by writing ones to them. A warm reset restarts the sequencer and leaves the flags as they are. Only a cold reset clears the flags. The interconnect debug handshake runs only when the interconnect is reset but the debug logic is kept alive. This is signalled by `dbg_kept`.

Top module: `wrhs_top`

## Requirements
- R1: Requests are issued one at a time, never two together, in this order: `hs_req[0]` SDRAM self-refresh, `hs_req[1]` FPGA, `hs_req[2]` trace stall, `hs_req[3]` L2 flush, `hs_req[4]` interconnect debug. The first request is raised on the clock edge that samples `seq_start` while the sequencer is idle.
- R2: A request stays high until the first edge at which its acknowledge is seen high. If no acknowledge arrives, it stays high for exactly TIMEOUT_CYC cycles. An acknowledge seen on the last of those cycles still counts as in time.
- R3: A timeout sets a flag at its own status bit: agent 0 sets bit 0, agent 1 sets bit 2, agent 2 sets bit 3, agent 3 sets bit 8, agent 4 sets bit 16. An acknowledged handshake sets no flag.
- R4: A timeout never stalls the sequence. `seq_done` is high for exactly one cycle, on the edge that ends the last handshake. An acknowledged handshake takes 1 cycle and a timed-out one takes TIMEOUT_CYC cycles.
- R5: The agent 4 handshake runs only when `dbg_kept` is 1. Otherwise the sequence ends after agent 3.
- R6: `cold_rst` (synchronous, active high) clears every flag, drops all requests and clears `seq_done`.
- R7: `warm_rst` leaves all flags unchanged. It returns the sequencer to idle with no request and no done pulse.
- R8: A write sets `reg_wr_en` with data on `reg_wdata`. Each 1 in the write data clears the matching flag. A 0 leaves that flag unchanged.
- R9: If a timeout sets a flag on the same edge that a write clears it, the flag ends up set.
- R10: Bits other than 0, 2, 3, 8 and 16 always read 0, and writes to them have no effect.
- R11: `reg_rdata` shows the status word as it was one cycle earlier.
- R12: `seq_start` is ignored while a sequence is running. No flag is set while the sequencer is idle, whatever the acknowledges do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous cold reset, clears everything |
| warm_rst | input | 1 | Synchronous warm reset, resets the sequencer only |
| seq_start | input | 1 | Starts the handshake sequence |
| dbg_kept | input | 1 | Debug logic stays out of reset, so the agent 4 handshake is needed |
| hs_ack | input | 5 | Acknowledges from the agents |
| hs_req | output | 5 | Requests to the agents |
| seq_done | output | 1 | One-cycle pulse when the reset may proceed |
| reg_wr_en | input | 1 | Status write strobe (write-one-to-clear) |
| reg_wdata | input | 32 | Status write data |
| reg_rdata | output | 32 | Status read data |

## Verification
The bench sweeps every acknowledge pattern of the five agents, with the debug handshake both enabled and disabled. For each case it predicts the flag word and the exact cycle of the done pulse. A wrong bit mapping, a skipped debug handshake, or a sequence that waits on a timed-out agent shows up there as a wrong word or a late pulse. Directed cases cover the rest:
- An acknowledge on the last allowed cycle against one a cycle late catches an off-by-one counter.
- A write-one that lands on the same edge as a timeout catches a clear that wins over the set.
- Warm reset, both idle and mid-sequence, catches flags that are lost or a done pulse that still fires after the sequence was aborted.
- Partial and reserved-bit writes catch write-zero clears and reserved bits that can be written.

// File: rtl/wrhs_pkg.sv
package wrhs_pkg;
  localparam int N_AGENT = 5;
  localparam int REG_W   = 32;

  typedef enum logic {SQ_IDLE = 1'b0, SQ_RUN = 1'b1} seq_state_e;

  // Status bit position for each agent; software decodes these.
  function automatic int flag_pos(input int agent);
    case (agent)
      0:       return 0;
      1:       return 2;
      2:       return 3;
      3:       return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] flag_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_AGENT; i++) m[flag_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/wrhs_timer.sv
module wrhs_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en && !expired) cnt_q <= cnt_q + 1'b1;
  end

  // Last cycle of the window: request has been high LIMIT cycles at the next edge.
  assign expired = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/wrhs_sequencer.sv
module wrhs_sequencer
  import wrhs_pkg::*;
#(
  parameter int N           = N_AGENT,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic         clk,
  input  logic         cold_rst,
  input  logic         warm_rst,
  input  logic         start,
  input  logic         dbg_kept,
  input  logic [N-1:0] hs_ack,
  output logic [N-1:0] hs_req,
  output logic [N-1:0] hs_to,
  output logic         seq_done
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  seq_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic [N-1:0]  req_q;
  logic          done_q;
  logic          ack_hit, expired, step, last_slot, tmr_clr, tmr_en, seq_rst;

  assign seq_rst   = cold_rst || warm_rst;
  assign ack_hit   = |(hs_ack & req_q);
  assign step      = (state_q == SQ_RUN) && (ack_hit || expired);
  // Final agent is optional: skipped when debug logic is reset along with the rest.
  assign last_slot = (idx_q == IW'(N - 1)) || ((idx_q == IW'(N - 2)) && !dbg_kept);
  assign tmr_clr   = (state_q == SQ_IDLE) || step;
  assign tmr_en    = (state_q == SQ_RUN);

  wrhs_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst     (seq_rst),
    .clr     (tmr_clr),
    .en      (tmr_en),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (seq_rst) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      req_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            state_q <= SQ_RUN;
            idx_q   <= '0;
            req_q   <= N'(1);
          end
        end
        SQ_RUN: begin
          if (step) begin
            if (last_slot) begin
              state_q <= SQ_IDLE;
              req_q   <= '0;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
              req_q <= req_q << 1;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign hs_req   = req_q;
  assign hs_to    = (step && !ack_hit) ? req_q : '0;
  assign seq_done = done_q;
endmodule

// File: rtl/wrhs_status.sv
module wrhs_status
  import wrhs_pkg::*;
#(
  parameter int N = N_AGENT,
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         cold_rst,
  input  logic [N-1:0] hs_to,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] set_vec,
  output logic [W-1:0] status,
  output logic [W-1:0] rdata
);
  logic [W-1:0] status_q, rdata_q, clr_vec;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < N; i++) set_vec[flag_pos(i)] = set_vec[flag_pos(i)] | hs_to[i];
  end

  assign clr_vec = wr_en ? wdata : '0;

  // Warm reset is deliberately absent: flags are sticky across it.
  always_ff @(posedge clk) begin
    if (cold_rst) begin
      status_q <= '0;
      rdata_q  <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_vec;
      rdata_q  <= status_q;
    end
  end

  assign status = status_q;
  assign rdata  = rdata_q;
endmodule

// File: rtl/wrhs_top.sv
module wrhs_top
  import wrhs_pkg::*;
#(
  parameter int TIMEOUT_CYC = 256
) (
  input  logic               clk,
  input  logic               cold_rst,
  input  logic               warm_rst,
  input  logic               seq_start,
  input  logic               dbg_kept,
  input  logic [N_AGENT-1:0] hs_ack,
  output logic [N_AGENT-1:0] hs_req,
  output logic               seq_done,
  input  logic               reg_wr_en,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata
);
  logic [N_AGENT-1:0] hs_to;
  logic [REG_W-1:0]   set_vec, status_q;

  wrhs_sequencer #(.N(N_AGENT), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk      (clk),
    .cold_rst (cold_rst),
    .warm_rst (warm_rst),
    .start    (seq_start),
    .dbg_kept (dbg_kept),
    .hs_ack   (hs_ack),
    .hs_req   (hs_req),
    .hs_to    (hs_to),
    .seq_done (seq_done)
  );

  wrhs_status #(.N(N_AGENT), .W(REG_W)) u_stat (
    .clk      (clk),
    .cold_rst (cold_rst),
    .hs_to    (hs_to),
    .wr_en    (reg_wr_en),
    .wdata    (reg_wdata),
    .set_vec  (set_vec),
    .status   (status_q),
    .rdata    (reg_rdata)
  );
endmodule

// File: rtl/wrhs_checker.sv
module wrhs_checker
  import wrhs_pkg::*;
(
  input logic               clk,
  input logic               cold_rst,
  input logic               warm_rst,
  input logic [N_AGENT-1:0] hs_req,
  input logic [N_AGENT-1:0] hs_ack,
  input logic [N_AGENT-1:0] hs_to,
  input logic               seq_done,
  input logic               reg_wr_en,
  input logic [REG_W-1:0]   set_vec,
  input logic [REG_W-1:0]   status_q,
  input logic [REG_W-1:0]   reg_rdata
);
  localparam logic [REG_W-1:0] MASK = flag_mask();

  assert_req_onehot_R1: assert property (@(posedge clk) disable iff (cold_rst)
    $onehot0(hs_req));

  assert_req_held_R2: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    (hs_req != '0 && (hs_req & hs_ack) == '0 && hs_to == '0) |=> hs_req == $past(hs_req));

  // Also covers R9: a set lands even when a clear is written on the same edge.
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (cold_rst)
    (set_vec != '0) |=> (status_q & $past(set_vec)) == $past(set_vec));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (cold_rst)
    seq_done |=> !seq_done);

  assert_cold_clear_R6: assert property (@(posedge clk)
    cold_rst |=> (status_q == '0 && hs_req == '0 && !seq_done));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (cold_rst)
    (!reg_wr_en && set_vec == '0) |=> $stable(status_q));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (cold_rst)
    (reg_rdata & ~MASK) == '0);

  assert_read_lag_R11: assert property (@(posedge clk) disable iff (cold_rst)
    1'b1 |=> reg_rdata == $past(status_q));
endmodule

bind wrhs_top wrhs_checker u_chk (
  .clk       (clk),
  .cold_rst  (cold_rst),
  .warm_rst  (warm_rst),
  .hs_req    (hs_req),
  .hs_ack    (hs_ack),
  .hs_to     (hs_to),
  .seq_done  (seq_done),
  .reg_wr_en (reg_wr_en),
  .set_vec   (set_vec),
  .status_q  (status_q),
  .reg_rdata (reg_rdata)
);

// File: tb/wrhs_top_tb.sv
module wrhs_top_tb;
  localparam int TO = 8;

  logic        clk = 1'b0;
  logic        cold_rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic        seq_start = 1'b0;
  logic        dbg_kept = 1'b0;
  logic [4:0]  ack_drv = '0;
  logic [4:0]  hs_req;
  logic        seq_done;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int pos [5] = '{0, 2, 3, 8, 16};

  always #10 clk = ~clk;

  wrhs_top #(.TIMEOUT_CYC(TO)) u_dut (
    .clk       (clk),
    .cold_rst  (cold_rst),
    .warm_rst  (warm_rst),
    .seq_start (seq_start),
    .dbg_kept  (dbg_kept),
    .hs_ack    (ack_drv),
    .hs_req    (hs_req),
    .seq_done  (seq_done),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_flags(input logic [4:0] ackm, input logic kd);
    logic [31:0] f = '0;
    for (int i = 0; i < 5; i++)
      if ((i < 4 || kd) && !ackm[i]) f[pos[i]] = 1'b1;
    return f;
  endfunction

  function automatic int exp_time(input logic [4:0] ackm, input logic kd);
    int t = 0;
    for (int i = 0; i < 5; i++)
      if (i < 4 || kd) t += ackm[i] ? 1 : TO;
    return t + 1;
  endfunction

  task automatic wr(input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
    @(negedge clk);
  endtask

  // Starts a sequence; returns negedges from the start edge to the done pulse.
  task automatic run_seq(input logic [4:0] ackm, input logic kd, input bit restart, output int n);
    ack_drv = ackm; dbg_kept = kd; seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
    n = 1;
    while (!seq_done && n < 1000) begin
      seq_start = (restart && n == 2);
      @(negedge clk);
      n++;
    end
    seq_start = 1'b0;
  endtask

  task automatic wait_done();
    int g = 0;
    while (!seq_done && g < 1000) begin @(negedge clk); g++; end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    cold_rst = 1'b0;
    check("R6 reset req", {27'b0, hs_req}, 32'h0);
    check("R6 reset done", {31'b0, seq_done}, 32'h0);
    check("R6 reset rdata", reg_rdata, 32'h0);

    // R12: idle with no acks for a long time sets nothing
    ack_drv = '0;
    repeat (3 * TO) @(negedge clk);
    check("R12 idle no flags", reg_rdata, 32'h0);
    check("R12 idle no req", {27'b0, hs_req}, 32'h0);

    // R1/R2: order and hold length with every agent silent
    dbg_kept = 1'b1; seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check($sformatf("R1 slot%0d first", k), {27'b0, hs_req}, 32'(1 << k));
      repeat (TO - 1) @(negedge clk);
      check($sformatf("R2 slot%0d last", k), {27'b0, hs_req}, 32'(1 << k));
      @(negedge clk);
    end
    check("R4 done after all timeouts", {31'b0, seq_done}, 32'h1);
    @(negedge clk);
    check("R3 all flags", reg_rdata, 32'h0001_010D);

    // R8/R10: partial clears, zero writes, reserved writes
    wr(32'h0000_0004);
    @(negedge clk);
    check("R8 clear bit2 only", reg_rdata, 32'h0001_0109);
    wr(32'h0000_0000);
    @(negedge clk);
    check("R8 write zero no effect", reg_rdata, 32'h0001_0109);
    wr(~32'h0001_010D);
    @(negedge clk);
    check("R10 reserved write no effect", reg_rdata, 32'h0001_0109);

    // R7: warm reset idle keeps flags
    warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 warm keeps flags", reg_rdata, 32'h0001_0109);

    // R6: cold reset clears flags
    cold_rst = 1'b1; @(negedge clk); cold_rst = 1'b0;
    @(negedge clk);
    check("R6 cold clears flags", reg_rdata, 32'h0);

    // R7: warm reset mid-sequence aborts without done
    begin
      int seen = 0;
      ack_drv = '0; dbg_kept = 1'b1; seq_start = 1'b1;
      @(negedge clk);
      seq_start = 1'b0;
      @(negedge clk);
      warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
      check("R7 warm drops req", {27'b0, hs_req}, 32'h0);
      for (int c = 0; c < 8 * TO; c++) begin
        @(negedge clk);
        if (seq_done || hs_req != '0) seen++;
      end
      check("R7 aborted sequence silent", 32'(seen), 32'h0);
      check("R7 aborted no flags", reg_rdata, 32'h0);
    end

    // R2 boundary: ack on last allowed cycle is in time
    ack_drv = '0; dbg_kept = 1'b0; seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
    repeat (TO - 1) @(negedge clk);
    ack_drv = 5'h1F;
    wait_done();
    check("R2 ack on last cycle", reg_rdata, 32'h0);
    // one cycle late is a timeout
    ack_drv = '0; seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
    repeat (TO) @(negedge clk);
    ack_drv = 5'h1F;
    wait_done();
    check("R2 ack one cycle late", reg_rdata, 32'h1);
    wr(32'hFFFF_FFFF);

    // R9: write-one clear on the same edge as the timeout
    ack_drv = '0; dbg_kept = 1'b0; seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
    repeat (TO - 1) @(negedge clk);
    reg_wr_en = 1'b1; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
    wait_done();
    check("R9 set wins over clear", reg_rdata & 32'h1, 32'h1);
    wr(32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 clear all", reg_rdata, 32'h0);

    // R12: restart while busy is ignored
    run_seq(5'h1F, 1'b1, 1'b1, n);
    check("R12 restart ignored timing", 32'(n), 32'(exp_time(5'h1F, 1'b1)));
    begin
      int extra = 0;
      for (int c = 0; c < 3 * TO; c++) begin
        @(negedge clk);
        if (seq_done || hs_req != '0) extra++;
      end
      check("R12 no second sequence", 32'(extra), 32'h0);
    end

    // Sweep: every ack pattern, debug handshake on and off (R3 R4 R5)
    for (int p = 0; p < 32; p++) begin
      for (int k = 0; k < 2; k++) begin
        run_seq(5'(p), k[0], 1'b0, n);
        check($sformatf("R4 done time p=%0d kd=%0d", p, k), 32'(n), 32'(exp_time(5'(p), k[0])));
        @(negedge clk);
        check($sformatf("R4 done width p=%0d kd=%0d", p, k), {31'b0, seq_done}, 32'h0);
        check($sformatf("R3 R5 flags p=%0d kd=%0d", p, k), reg_rdata, exp_flags(5'(p), k[0]));
        wr(32'hFFFF_FFFF);
      end
    end
    ack_drv = '0;

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule